// File: doc/BRIEF.md
# Indexed Control-Address Bridge

This bridge lets a host with a small address budget reach a target controller whose slave port takes a 28-bit control address. A direct mapping of that port would need a 256 MB window. The host instead sees a few word registers. It writes a control word into an index register once. Each later access to the data register becomes one target access at the latched control address, with the host's write data or with the target's read data returned.

The bridge passes the control address through unchanged. The target decodes it. Bits [27:26] select the access kind and bits [25:24] select the bank. The low bits hold the block and page. The index stays latched, so a whole page can be streamed through the data register with no further index writes. A read-only capability register reports that indexed addressing is built in.

The host side uses a one-cycle request strobe and a one-cycle ready pulse. The target side holds its request until the target acknowledges it.

Top module: `idx_bridge`

## Requirements
- R1: After reset, `ready_o` and `tgt_req_o` are low and the index register reads 0.
- R2: A write to offset 0x00 latches bits [27:0] of the write data as the control address and ignores bits [31:28]. A read of offset 0x00 returns the latched value with bits [31:28] zero.
- R3: A write to offset 0x10 raises `tgt_req_o` one cycle after the request, with `tgt_we_o`=1, `tgt_addr_o` equal to the latched control address (mode bits [27:26] and bank bits [25:24] unchanged), and `tgt_wdata_o` equal to the host data.
- R4: A read of offset 0x10 raises `tgt_req_o` with `tgt_we_o`=0 at the latched address. The value of `tgt_rdata_i` in the acknowledging cycle appears on `rdata_o` together with `ready_o`, and it stays there until the next host read completes.
- R5: Consecutive data-register accesses with no index write in between each make exactly one target access, all at the same control address.
- R6: A read of offset 0x20 returns 1 in bit 0 (indexed mode present) and 0 in the other bits. Writes to offset 0x20 have no effect.
- R7: An access to any offset other than 0x00, 0x10 or 0x20 completes with `ready_o` one cycle after the request. A read returns 0. Neither a read nor a write makes a target access.
- R8: While `tgt_ack_i` is low, `tgt_req_o`, `tgt_we_o`, `tgt_addr_o` and `tgt_wdata_o` stay unchanged. In the cycle after the acknowledge, `tgt_req_o` is low and `ready_o` is high. Local accesses raise `ready_o` one cycle after the request.
- R9: A request strobe that arrives while a target access is outstanding is ignored. It makes no target access and does not change the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request strobe, one cycle |
| we_i | input | 1 | Host write (1) or read (0) |
| off_i | input | 8 | Host byte offset within the window |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Host read data, held until the next read completes |
| ready_o | output | 1 | One-cycle completion pulse |
| tgt_req_o | output | 1 | Target access request, held until acknowledged |
| tgt_we_o | output | 1 | Target access is a write |
| tgt_addr_o | output | 28 | Target control address |
| tgt_wdata_o | output | 32 | Target write data |
| tgt_rdata_i | input | 32 | Target read data, valid with the acknowledge |
| tgt_ack_i | input | 1 | Target acknowledge |

## Verification
The hardest case to reach from the ports is a host strobe that lands while a target access is still outstanding. The bench slows its target responder to six wait cycles and fires an index write and a data write into that gap. It then reads the index back and counts target acknowledges, which shows that neither strobe had any effect. A behavioural model predicts every output on every clock. The responder returns a different word on each read, so a page stream that repeats stale data fails the comparison.

// File: rtl/idx_bridge_pkg.sv
package idx_bridge_pkg;
  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_INDEX = 2'd1,
    SEL_DATA  = 2'd2,
    SEL_CAP   = 2'd3
  } win_sel_e;

  localparam int CAP_INDEXED_BIT = 0;
endpackage

// File: rtl/idx_bridge_regs.sv
module idx_bridge_regs
  import idx_bridge_pkg::*;
#(
  parameter int OFF_W     = 8,
  parameter int DATA_W    = 32,
  parameter int CTRL_W    = 28,
  parameter int OFF_INDEX = 'h00,
  parameter int OFF_DATA  = 'h10,
  parameter int OFF_CAP   = 'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output win_sel_e          sel_o,
  output logic [CTRL_W-1:0] index_o,
  output logic [DATA_W-1:0] local_rdata_o
);
  localparam logic [OFF_W-1:0] OffIndex = OFF_W'(OFF_INDEX);
  localparam logic [OFF_W-1:0] OffData  = OFF_W'(OFF_DATA);
  localparam logic [OFF_W-1:0] OffCap   = OFF_W'(OFF_CAP);

  logic [CTRL_W-1:0] index_q;

  always_comb begin
    if (off_i == OffIndex)     sel_o = SEL_INDEX;
    else if (off_i == OffData) sel_o = SEL_DATA;
    else if (off_i == OffCap)  sel_o = SEL_CAP;
    else                       sel_o = SEL_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) index_q <= '0;
    else if (accept_i && we_i && sel_o == SEL_INDEX) index_q <= wdata_i;
  end

  always_comb begin
    local_rdata_o = '0;
    unique case (sel_o)
      SEL_INDEX: local_rdata_o = DATA_W'(index_q);
      SEL_CAP:   local_rdata_o[CAP_INDEXED_BIT] = 1'b1;
      default:   local_rdata_o = '0;
    endcase
  end

  assign index_o = index_q;

  // index changes only through an accepted index write
  p_index_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_i && we_i && sel_o == SEL_INDEX) |=> $stable(index_q));
endmodule

// File: rtl/idx_bridge_tgt.sv
module idx_bridge_tgt #(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tgt_ack_i,
  output logic              busy_o,
  output logic              fire_o,
  output logic              fire_rd_o,
  output logic              tgt_req_o,
  output logic              tgt_we_o,
  output logic [CTRL_W-1:0] tgt_addr_o,
  output logic [DATA_W-1:0] tgt_wdata_o
);
  logic              req_q, we_q;
  logic [CTRL_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (req_q) begin
      if (tgt_ack_i) req_q <= 1'b0;
    end else if (start_i) begin
      req_q   <= 1'b1;
      we_q    <= we_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  assign busy_o      = req_q;
  assign fire_o      = req_q & tgt_ack_i;
  assign fire_rd_o   = req_q & tgt_ack_i & ~we_q;
  assign tgt_req_o   = req_q;
  assign tgt_we_o    = we_q;
  assign tgt_addr_o  = addr_q;
  assign tgt_wdata_o = wdata_q;

  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_req_o && !tgt_ack_i |=> tgt_req_o && $stable(tgt_addr_o)
                                && $stable(tgt_we_o) && $stable(tgt_wdata_o));
endmodule

// File: rtl/idx_bridge_resp.sv
module idx_bridge_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              local_done_i,
  input  logic              local_rd_i,
  input  logic [DATA_W-1:0] local_rdata_i,
  input  logic              tgt_done_i,
  input  logic              tgt_rd_i,
  input  logic [DATA_W-1:0] tgt_rdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      ready_o <= local_done_i | tgt_done_i;
      if (tgt_rd_i)        rdata_o <= tgt_rdata_i;
      else if (local_rd_i) rdata_o <= local_rdata_i;
    end
  end

  p_rdata_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !local_rd_i && !tgt_rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/idx_bridge.sv
module idx_bridge
  import idx_bridge_pkg::*;
#(
  parameter int OFF_W     = 8,
  parameter int DATA_W    = 32,
  parameter int CTRL_W    = 28,
  parameter int OFF_INDEX = 'h00,
  parameter int OFF_DATA  = 'h10,
  parameter int OFF_CAP   = 'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              tgt_req_o,
  output logic              tgt_we_o,
  output logic [CTRL_W-1:0] tgt_addr_o,
  output logic [DATA_W-1:0] tgt_wdata_o,
  input  logic [DATA_W-1:0] tgt_rdata_i,
  input  logic              tgt_ack_i
);
  win_sel_e          sel;
  logic [CTRL_W-1:0] index;
  logic [DATA_W-1:0] local_rdata;
  logic              busy, accept, start, local_done, local_rd, fire, fire_rd;

  assign accept     = req_i & ~busy;
  assign start      = accept & (sel == SEL_DATA);
  assign local_done = accept & (sel != SEL_DATA);
  assign local_rd   = local_done & ~we_i;

  idx_bridge_regs #(
    .OFF_W(OFF_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W),
    .OFF_INDEX(OFF_INDEX), .OFF_DATA(OFF_DATA), .OFF_CAP(OFF_CAP)
  ) i_regs (
    .clk_i, .rst_ni,
    .accept_i      (accept),
    .we_i,
    .off_i,
    .wdata_i       (wdata_i[CTRL_W-1:0]),
    .sel_o         (sel),
    .index_o       (index),
    .local_rdata_o (local_rdata)
  );

  idx_bridge_tgt #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) i_tgt (
    .clk_i, .rst_ni,
    .start_i     (start),
    .we_i,
    .addr_i      (index),
    .wdata_i,
    .tgt_ack_i,
    .busy_o      (busy),
    .fire_o      (fire),
    .fire_rd_o   (fire_rd),
    .tgt_req_o,
    .tgt_we_o,
    .tgt_addr_o,
    .tgt_wdata_o
  );

  idx_bridge_resp #(.DATA_W(DATA_W)) i_resp (
    .clk_i, .rst_ni,
    .local_done_i  (local_done),
    .local_rd_i    (local_rd),
    .local_rdata_i (local_rdata),
    .tgt_done_i    (fire),
    .tgt_rd_i      (fire_rd),
    .tgt_rdata_i,
    .ready_o,
    .rdata_o
  );

  p_data_issue_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !tgt_req_o && sel == SEL_DATA |=>
      tgt_req_o && tgt_addr_o == $past(index) && tgt_we_o == $past(we_i));

  p_ready_after_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_req_o && tgt_ack_i |=> ready_o && !tgt_req_o);

  p_no_tgt_local_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !tgt_req_o && sel != SEL_DATA |=> !tgt_req_o && ready_o);

  p_busy_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_req_o |=> $stable(index));
endmodule

// File: tb/test_idx_bridge.sv
module test_idx_bridge;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  off = '0;
  logic [31:0] wdata = '0, rdata, tgt_wdata, tgt_rdata = 32'hC0DE_0000;
  logic        ready, tgt_req, tgt_we, tgt_ack = 1'b0;
  logic [27:0] tgt_addr;

  int n_tests = 0, n_fail = 0;

  idx_bridge i_idx_bridge (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .off_i(off),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready), .tgt_req_o(tgt_req),
    .tgt_we_o(tgt_we), .tgt_addr_o(tgt_addr), .tgt_wdata_o(tgt_wdata),
    .tgt_rdata_i(tgt_rdata), .tgt_ack_i(tgt_ack));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // target responder
  int lat = 0, wait_cnt = 0, rd_seq = 0;
  always @(negedge clk) begin
    if (tgt_ack) begin
      tgt_ack = 1'b0; rd_seq++; tgt_rdata = 32'hC0DE_0000 + rd_seq; wait_cnt = 0;
    end else if (tgt_req) begin
      if (wait_cnt >= lat) tgt_ack = 1'b1; else wait_cnt++;
    end
  end

  // target access log
  int          n_tgt = 0;
  logic [27:0] last_addr;
  logic [31:0] last_wdata, last_fire_rdata;
  logic        last_we;
  always @(posedge clk) if (tgt_req && tgt_ack) begin
    n_tgt++; last_addr = tgt_addr; last_we = tgt_we;
    last_wdata = tgt_wdata; last_fire_rdata = tgt_rdata;
  end

  // behavioural reference model
  logic [27:0] m_index;
  logic [31:0] m_rdata, m_twdata;
  logic [27:0] m_taddr;
  logic        m_ready, m_treq, m_twe;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_index <= '0; m_rdata <= '0; m_ready <= 1'b0; m_treq <= 1'b0;
      m_twe <= 1'b0; m_taddr <= '0; m_twdata <= '0;
    end else begin
      m_ready <= 1'b0;
      if (m_treq) begin
        if (tgt_ack) begin
          m_treq <= 1'b0; m_ready <= 1'b1;
          if (!m_twe) m_rdata <= tgt_rdata;
        end
      end else if (req) begin
        if (off == 8'h10) begin
          m_treq <= 1'b1; m_twe <= we; m_taddr <= m_index; m_twdata <= wdata;
        end else begin
          m_ready <= 1'b1;
          if (off == 8'h00) begin
            if (we) m_index <= wdata[27:0]; else m_rdata <= {4'h0, m_index};
          end else if (!we) m_rdata <= (off == 8'h20) ? 32'd1 : 32'd0;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(ready === m_ready, "R8 ready timing", {31'd0, ready}, {31'd0, m_ready});
    chk(tgt_req === m_treq, "R8 target request", {31'd0, tgt_req}, {31'd0, m_treq});
    if (m_treq) begin
      chk(tgt_addr === m_taddr, "R3 target address", {4'h0, tgt_addr}, {4'h0, m_taddr});
      chk(tgt_we === m_twe, "R3 target direction", {31'd0, tgt_we}, {31'd0, m_twe});
      if (m_twe) chk(tgt_wdata === m_twdata, "R3 target wdata", tgt_wdata, m_twdata);
    end
    chk(rdata === m_rdata, "R4 host rdata", rdata, m_rdata);
  end

  task automatic pulse(input logic w, input logic [7:0] o, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = w; off = o; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic access(input logic w, input logic [7:0] o, input logic [31:0] d, output logic [31:0] r);
    pulse(w, o, d);
    for (int i = 0; i < 100 && !ready; i++) @(negedge clk);
    r = rdata;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r, prev;
    int n0;
    repeat (3) @(negedge clk);
    chk(ready === 1'b0, "R1 ready in reset", {31'd0, ready}, 32'd0);
    chk(tgt_req === 1'b0, "R1 tgt_req in reset", {31'd0, tgt_req}, 32'd0);
    rst_n = 1'b1;
    access(1'b0, 8'h00, '0, r);
    chk(r === 32'd0, "R1 index after reset", r, 32'd0);

    access(1'b1, 8'h00, 32'hF9AB_CDEF, r);
    access(1'b0, 8'h00, '0, r);
    chk(r === 32'h09AB_CDEF, "R2 index readback", r, 32'h09AB_CDEF);

    access(1'b0, 8'h20, '0, r);
    chk(r === 32'd1, "R6 capability", r, 32'd1);
    access(1'b1, 8'h20, 32'h0, r);
    access(1'b0, 8'h20, '0, r);
    chk(r === 32'd1, "R6 capability after write", r, 32'd1);

    n0 = n_tgt;
    access(1'b0, 8'h30, '0, r);
    chk(r === 32'd0, "R7 unmapped read", r, 32'd0);
    access(1'b1, 8'h44, 32'h1234_5678, r);
    repeat (3) @(negedge clk);
    chk(n_tgt == n0, "R7 no target access", n_tgt, n0);

    lat = 2;
    access(1'b1, 8'h00, {4'h0, 2'b10, 2'b11, 24'h00_1234}, r);
    access(1'b1, 8'h10, 32'h5A5A_0001, r);
    chk(last_we === 1'b1, "R3 write direction", {31'd0, last_we}, 32'd1);
    chk(last_addr === {2'b10, 2'b11, 24'h00_1234}, "R3 mode/bank address",
        {4'h0, last_addr}, {4'h0, 2'b10, 2'b11, 24'h00_1234});
    chk(last_wdata === 32'h5A5A_0001, "R3 write data", last_wdata, 32'h5A5A_0001);

    lat = 0;
    access(1'b1, 8'h00, {4'hE, 2'b01, 2'b01, 24'h00_0077}, r);
    prev = '0;
    for (int k = 0; k < 4; k++) begin
      n0 = n_tgt;
      access(1'b0, 8'h10, '0, r);
      chk(r === last_fire_rdata, "R4 streamed read data", r, last_fire_rdata);
      chk(r !== prev, "R5 fresh word per read", r, ~prev);
      chk(n_tgt == n0 + 1, "R5 one access per read", n_tgt, n0 + 1);
      chk(last_addr === {2'b01, 2'b01, 24'h00_0077}, "R5 same address",
          {4'h0, last_addr}, {4'h0, 2'b01, 2'b01, 24'h00_0077});
      prev = r;
    end
    repeat (2) @(negedge clk);
    chk(rdata === prev, "R4 rdata held", rdata, prev);

    lat = 1;
    for (int k = 0; k < 3; k++) begin
      access(1'b1, 8'h10, 32'hA000_0000 + k, r);
      chk(last_wdata === 32'hA000_0000 + k, "R5 streamed write", last_wdata, 32'hA000_0000 + k);
    end

    lat = 6;
    n0 = n_tgt;
    pulse(1'b0, 8'h10, '0);
    pulse(1'b1, 8'h00, 32'h0FFF_FFFF);
    pulse(1'b1, 8'h10, 32'hDEAD_BEEF);
    for (int i = 0; i < 100 && !ready; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(n_tgt == n0 + 1, "R9 strobes ignored while busy", n_tgt, n0 + 1);
    lat = 0;
    access(1'b0, 8'h00, '0, r);
    chk(r === {4'h0, 2'b01, 2'b01, 24'h00_0077}, "R9 index unchanged", r,
        {4'h0, 2'b01, 2'b01, 24'h00_0077});

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule